// File: doc/BRIEF.md
# Bus-Programmed Channel Enable Controller

This block is a two-wire serial target that owns a single byte of control state and turns its low bits into a set of channel-enable outputs. A bus controller addresses the block, writes a byte to select any mix of downstream channels, and may read the byte back. The enables feed switch logic elsewhere in the chip. That logic connects or isolates downstream bus segments.

A newly written selection is not applied when its byte is acknowledged. It is held as pending and applied only when the controller ends the transaction with a STOP. Channels therefore change only while the bus is idle. The serial clock and data inputs are first synchronized and majority-filtered so that one-sample spikes cannot create clock edges or bus conditions. The data pin is driven as an open-drain pull-down request.

Top module: `chansel_i2c_target`

## Requirements
- R1: The block answers to the 7-bit address formed by the fixed high bits 1110 followed by strap_addr[2:0], acknowledging a match. On a mismatch it never pulls SDA again until the next START.
- R2: The bit after the seven address bits selects the direction: 1 is a read of the control byte and 0 is a write to it.
- R3: When a write carries several data bytes, each is acknowledged and the last one received is the one kept.
- R4: Control bit n (n = 0..3) drives chan_en[n] one-for-one, and any combination is allowed. Bits 7:4 have no effect on chan_en but are stored and read back.
- R5: A written selection reaches chan_en only after a STOP is seen. chan_en holds its old value through the data acknowledge and up to the STOP.
- R6: A low rst_n at a clock edge clears the control byte, any pending selection, the bus state machine and chan_en to zero, and releases SDA.
- R7: A read shifts the full control byte out MSB first and releases SDA for the controller's acknowledge bit. An ACK from the controller sends the byte again, and a NACK ends the read with SDA released.
- R8: The block acknowledges a matching address and every written byte by pulling SDA low through the high period of the ninth clock. It changes its pull only while SCL is low.
- R9: A repeated START restarts address reception, and a selection written before it stays unapplied until a STOP.
- R10: A single-sample spike on SCL or on SDA is rejected by the input filter and neither adds a clock edge nor creates a bus condition.
- R11: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high. A STOP in the middle of a data byte discards the partial byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired-AND bus value) |
| strap_addr | input | 3 | Low three address bits from board straps |
| sda_pull | output | 1 | 1 requests the open-drain SDA driver to pull low |
| chan_en | output | 4 | Applied channel enables, bit n for channel n |

## Verification
The bench builds the block with its default parameters: four channels, a three-tap majority filter and a three-bit strap. The strap is narrow enough to sweep every strap value against every low address, so that all 64 match and mismatch pairs are covered. The four-bit channel field is narrow enough to write and read back all sixteen selections, each paired with a distinct upper nibble. On that small configuration the bench also places repeated STARTs, multi-byte writes, a STOP in the middle of a byte, single-sample spikes and a reset while a selection is pending.

// File: rtl/chsel_pkg.sv
// Shared types for the channel enable controller.
// Assumes: one bus event at most per clock, as produced by chsel_bus_events.
package chsel_pkg;

    // Target state machine states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } tgt_state_e;

    // Single-cycle bus events decoded from the filtered lines.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

endpackage

// File: rtl/chsel_line_filter.sv
// Input conditioner for one bus line: a two-flop synchronizer followed by
// a TAPS-sample majority vote and a registered output.
// Assumes: TAPS is odd and at least 3; the idle bus level is IDLE_LEVEL.
module chsel_line_filter #(
    parameter int   TAPS       = 3,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int SYNC_W = 2;
    localparam int HALF   = TAPS / 2;
    localparam int ONES_W = $clog2(TAPS + 1);

    logic [SYNC_W-1:0] sync_q;
    logic [TAPS-1:0]   hist_q;
    logic              clean_q;
    logic [ONES_W-1:0] ones_c;
    logic              vote_c;

    // Synchronize the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_W{IDLE_LEVEL}};
        else        sync_q <= {sync_q[SYNC_W-2:0], raw};
    end

    // Keep the last TAPS synchronized samples.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= {TAPS{IDLE_LEVEL}};
        else        hist_q <= {hist_q[TAPS-2:0], sync_q[SYNC_W-1]};
    end

    // Count the high samples and take the majority.
    always_comb begin
        ones_c = '0;
        for (int i = 0; i < TAPS; i++) ones_c = ones_c + ONES_W'(hist_q[i]);
        vote_c = (ones_c > ONES_W'(HALF));
    end

    // Register the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) clean_q <= IDLE_LEVEL;
        else        clean_q <= vote_c;
    end

    assign clean = clean_q;

    // A level change needs two matching samples in a row of the history.
    AST_FILTER_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (clean_q != $past(clean_q))) |->
        ($past(hist_q[0]) == clean_q || $past(hist_q[1]) == clean_q))
        else $error("filter changed on a lone sample"); // R10

endmodule

// File: rtl/chsel_bus_events.sv
// Decodes SCL edges and START/STOP conditions from the filtered lines.
// Assumes: both inputs have passed through identical filters, so their
// relative timing matches the bus.
module chsel_bus_events
    import chsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_c,
    input  logic     sda_c,
    output bus_evt_t ev
);
    logic scl_p;
    logic sda_p;

    // Remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_c;
            sda_p <= sda_c;
        end
    end

    // Classify the change seen this cycle.
    always_comb begin
        ev.scl_rise = scl_c & ~scl_p;
        ev.scl_fall = ~scl_c & scl_p;
        ev.start    = scl_c & scl_p & sda_p & ~sda_c;
        ev.stop     = scl_c & scl_p & ~sda_p & sda_c;
    end

    // At most one bus event in any cycle.
    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev.scl_rise, ev.scl_fall, ev.start, ev.stop}))
        else $error("overlapping bus events"); // R11

endmodule

// File: rtl/chsel_target_fsm.sv
// Serial target state machine: address match, byte receive, acknowledge,
// read shift-out, control byte storage and STOP-time channel update.
// Assumes: one event per cycle from chsel_bus_events; REG_W equals the
// address width plus the direction bit.
module chsel_target_fsm
    import chsel_pkg::*;
#(
    parameter int                  CHANNELS  = 4,
    parameter int                  REG_W     = 8,
    parameter int                  STRAP_W   = 3,
    parameter int                  ADDR_HI_W = 4,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI  = 4'b1110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bus_evt_t           ev,
    input  logic               scl_c,
    input  logic               sda_c,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_pull,
    output logic [CHANNELS-1:0] chan_en
);
    localparam int ADDR_W = ADDR_HI_W + STRAP_W;
    localparam int CNT_W  = $clog2(REG_W + 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(REG_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(REG_W - 1);

    tgt_state_e          state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [REG_W-1:0]    rx_q;
    logic [REG_W-1:0]    tx_q;
    logic [REG_W-1:0]    ctrl_q;
    logic                pend_q;
    logic [CHANNELS-1:0] chan_q;
    logic                pull_q;
    logic                rd_q;
    logic                nack_q;
    logic                match_c;

    // Compare the received address with the fixed bits plus the straps.
    assign match_c = (rx_q[REG_W-1:REG_W-ADDR_W] == {ADDR_HI, strap});

    // Bus protocol sequencing and register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            ctrl_q  <= '0;
            pend_q  <= 1'b0;
            chan_q  <= '0;
            pull_q  <= 1'b0;
            rd_q    <= 1'b0;
            nack_q  <= 1'b0;
        end else if (ev.start) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
        end else if (ev.stop) begin
            state_q <= ST_IDLE;
            pull_q  <= 1'b0;
            if (pend_q) begin
                chan_q <= ctrl_q[CHANNELS-1:0];
                pend_q <= 1'b0;
            end
        end else begin
            case (state_q)
                ST_ADDR, ST_WR: begin
                    if (ev.scl_rise && cnt_q != LAST_RX) begin
                        rx_q  <= {rx_q[REG_W-2:0], sda_c};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (ev.scl_fall && cnt_q == LAST_RX) begin
                        cnt_q <= '0;
                        if (state_q == ST_ADDR) begin
                            if (match_c) begin
                                rd_q    <= rx_q[0];
                                state_q <= ST_ADDR_ACK;
                                pull_q  <= 1'b1;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            ctrl_q  <= rx_q;
                            pend_q  <= 1'b1;
                            state_q <= ST_WR_ACK;
                            pull_q  <= 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        cnt_q <= '0;
                        if (rd_q) begin
                            tx_q    <= ctrl_q;
                            pull_q  <= ~ctrl_q[REG_W-1];
                            state_q <= ST_RD;
                        end else begin
                            pull_q  <= 1'b0;
                            state_q <= ST_WR;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (ev.scl_fall) begin
                        pull_q  <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (ev.scl_fall) begin
                        if (cnt_q == LAST_TX) begin
                            pull_q  <= 1'b0;
                            state_q <= ST_RD_ACK;
                        end else begin
                            tx_q   <= {tx_q[REG_W-2:0], 1'b0};
                            pull_q <= ~tx_q[REG_W-2];
                            cnt_q  <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev.scl_rise) nack_q <= sda_c;
                    if (ev.scl_fall) begin
                        cnt_q <= '0;
                        if (nack_q) begin
                            state_q <= ST_IDLE;
                        end else begin
                            tx_q    <= ctrl_q;
                            pull_q  <= ~ctrl_q[REG_W-1];
                            state_q <= ST_RD;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sda_pull = pull_q;
    assign chan_en  = chan_q;

    // Enables move only in the cycle after a STOP.
    AST_CHAN_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && chan_q != $past(chan_q)) |-> $past(ev.stop))
        else $error("enables changed without STOP"); // R5

    // Out of reset everything is at its default.
    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (chan_q == '0 && ctrl_q == '0 && !pull_q && !pend_q))
        else $error("reset state wrong"); // R6

    // The pull is never switched on while SCL is high.
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_q) |-> !scl_c)
        else $error("pull asserted with SCL high"); // R8

    // Acknowledge stays low while SCL is high.
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ADDR_ACK || state_q == ST_WR_ACK) && scl_c) |-> pull_q)
        else $error("acknowledge dropped during high phase"); // R8

    // An idle target never drives the bus.
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !pull_q)
        else $error("idle target pulling SDA"); // R1

endmodule

// File: rtl/chansel_i2c_target.sv
// Top of the channel enable controller: filters both bus lines, decodes
// bus events and runs the target state machine.
// Assumes: clk oversamples SCL by well over ten samples per phase; the
// pad logic turns sda_pull into an open-drain pull-down.
module chansel_i2c_target #(
    parameter int CHANNELS    = 4,
    parameter int STRAP_W     = 3,
    parameter int FILTER_TAPS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic [STRAP_W-1:0]  strap_addr,
    output logic                sda_pull,
    output logic [CHANNELS-1:0] chan_en
);
    import chsel_pkg::*;

    localparam int LINES = 2;
    localparam int REG_W = 8;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] clean_lines;
    bus_evt_t         ev;

    assign raw_lines = {scl_in, sda_in};

    // One conditioner per bus line.
    for (genvar g = 0; g < LINES; g++) begin : g_filt
        chsel_line_filter #(
            .TAPS       (FILTER_TAPS),
            .IDLE_LEVEL (1'b1)
        ) i_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    chsel_bus_events i_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_c (clean_lines[1]),
        .sda_c (clean_lines[0]),
        .ev    (ev)
    );

    chsel_target_fsm #(
        .CHANNELS (CHANNELS),
        .REG_W    (REG_W),
        .STRAP_W  (STRAP_W)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .scl_c    (clean_lines[1]),
        .sda_c    (clean_lines[0]),
        .strap    (strap_addr),
        .sda_pull (sda_pull),
        .chan_en  (chan_en)
    );

endmodule

// File: tb/test_chansel_i2c_target.sv
module test_chansel_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q  = 8;
    localparam int HP = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'd5;
    logic       sda_pull;
    logic [3:0] chan_en;
    logic       sda_line;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;
    bit         pull_seen = 0;

    assign sda_line = sda_m & ~sda_pull;

    chansel_i2c_target i_chansel_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .strap_addr(strap), .sda_pull(sda_pull), .chan_en(chan_en));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (sda_pull) pull_seen = 1'b1;

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(HP);
        sda_m = 1'b0; w(HP);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(HP);
        sda_m = 1'b1; w(HP);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; w(Q);
        scl_m = 1'b1; w(HP);
        scl_m = 1'b0; w(Q);
    endtask

    // Send a byte; scl_g/sda_g pick a bit position for a one-cycle spike.
    task automatic send_byte(input logic [7:0] b, input int scl_g, input int sda_g,
                             output bit ack);
        bit early, late;
        for (int i = 0; i < 8; i++) begin
            sda_m = b[7-i];
            if (i == scl_g) begin
                w(2); scl_m = 1'b1; w(1); scl_m = 1'b0; w(Q-3);
            end else w(Q);
            scl_m = 1'b1;
            if (i == sda_g) begin
                w(4); sda_m = 1'b0; w(1); sda_m = b[7-i]; w(HP-5);
            end else w(HP);
            scl_m = 1'b0; w(Q);
        end
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(1);
        early = !sda_line;
        w(HP-2);
        late = !sda_line;
        w(1);
        scl_m = 1'b0; w(Q);
        ack = early & late;
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            w(Q); scl_m = 1'b1; w(HP/2);
            b[7-i] = sda_line;
            w(HP/2); scl_m = 1'b0;
        end
        w(Q);
        sda_m = nack; w(Q);
        scl_m = 1'b1; w(HP);
        scl_m = 1'b0; w(Q);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] r, r2, d;
        logic [3:0] exp_chan;
        logic [7:0] a_w, a_r;

        w(4); rst_n = 1'b1; w(4);
        chk(chan_en == 4'h0, "R6 reset enables", chan_en, 0);
        chk(sda_pull == 1'b0, "R6 reset pull", sda_pull, 0);
        exp_chan = 4'h0;

        // R1/R2/R4 sweep of straps against addresses.
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 8; a++) begin
                bit match;
                strap = 3'(s);
                match = (s == a);
                d = {4'(a + 2*s), 4'(s ^ (a + 1))};
                bus_start();
                send_byte({4'b1110, 3'(a), 1'b0}, -1, -1, ack);
                chk(ack == match, "R1 address acknowledge", ack, match);
                pull_seen = 1'b0;
                send_byte(d, -1, -1, ack);
                if (!match) chk(!pull_seen, "R1 released after mismatch", pull_seen, 0);
                bus_stop();
                if (match) exp_chan = d[3:0];
                chk(chan_en == exp_chan, "R4 enables after write sweep", chan_en, exp_chan);
            end
        end

        strap = 3'd5;
        a_w = {4'b1110, 3'd5, 1'b0};
        a_r = {4'b1110, 3'd5, 1'b1};

        // R4/R5/R7/R2 every selection, written then read back.
        for (int k = 0; k < 16; k++) begin
            d = {4'((k*5 + 9) % 16), 4'(k)};
            bus_start();
            send_byte(a_w, -1, -1, ack);
            send_byte(d, -1, -1, ack);
            chk(ack, "R8 data acknowledge", ack, 1);
            chk(chan_en == exp_chan, "R5 held before STOP", chan_en, exp_chan);
            bus_stop();
            exp_chan = d[3:0];
            chk(chan_en == exp_chan, "R4 applied at STOP", chan_en, exp_chan);
            bus_start();
            send_byte(a_r, -1, -1, ack);
            recv_byte(1'b1, r);
            chk(r == d, "R7 R2 read back", r, d);
            chk(sda_pull == 1'b0, "R7 released after NACK", sda_pull, 0);
            bus_stop();
        end

        // R3 multi-byte write keeps the last byte.
        bus_start();
        send_byte(a_w, -1, -1, ack);
        send_byte(8'h11, -1, -1, ack);
        send_byte(8'h22, -1, -1, ack);
        send_byte(8'h3C, -1, -1, ack);
        chk(ack, "R3 third byte acknowledged", ack, 1);
        bus_stop();
        exp_chan = 4'hC;
        chk(chan_en == exp_chan, "R3 last byte applied", chan_en, exp_chan);

        // R7 continued read with controller ACK.
        bus_start();
        send_byte(a_r, -1, -1, ack);
        recv_byte(1'b0, r);
        recv_byte(1'b1, r2);
        chk(r == 8'h3C, "R7 first read byte", r, 8'h3C);
        chk(r2 == 8'h3C, "R7 repeated read byte", r2, 8'h3C);
        bus_stop();

        // R9 repeated START keeps the selection pending.
        bus_start();
        send_byte(a_w, -1, -1, ack);
        send_byte(8'h09, -1, -1, ack);
        bus_start();
        send_byte(a_r, -1, -1, ack);
        chk(ack, "R9 address after repeated START", ack, 1);
        recv_byte(1'b1, r);
        chk(r == 8'h09, "R9 read after repeated START", r, 8'h09);
        chk(chan_en == exp_chan, "R9 pending not applied", chan_en, exp_chan);
        bus_stop();
        exp_chan = 4'h9;
        chk(chan_en == exp_chan, "R9 applied at STOP", chan_en, exp_chan);

        // R10 single-sample spikes on SCL and SDA.
        bus_start();
        send_byte(a_w, 3, -1, ack);
        chk(ack, "R10 SCL spike ignored", ack, 1);
        send_byte(8'h5A, -1, 1, ack);
        chk(ack, "R10 SDA spike ignored", ack, 1);
        bus_stop();
        exp_chan = 4'hA;
        chk(chan_en == exp_chan, "R10 spiky write applied", chan_en, exp_chan);

        // R11 STOP inside a data byte drops the partial byte.
        bus_start();
        send_byte(a_w, -1, -1, ack);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        chk(chan_en == exp_chan, "R11 partial byte dropped", chan_en, exp_chan);
        bus_start();
        send_byte(a_r, -1, -1, ack);
        recv_byte(1'b1, r);
        chk(r == 8'h5A, "R11 register kept", r, 8'h5A);
        bus_stop();

        // R6 reset while a selection is pending.
        bus_start();
        send_byte(a_w, -1, -1, ack);
        send_byte(8'h0F, -1, -1, ack);
        rst_n = 1'b0; w(2); rst_n = 1'b1; w(2);
        chk(chan_en == 4'h0, "R6 enables cleared", chan_en, 0);
        chk(sda_pull == 1'b0, "R6 pull released", sda_pull, 0);
        scl_m = 1'b1; w(HP); sda_m = 1'b1; w(HP);
        bus_start();
        send_byte(a_r, -1, -1, ack);
        recv_byte(1'b1, r);
        chk(r == 8'h00, "R6 register cleared", r, 0);
        bus_stop();
        chk(chan_en == 4'h0, "R6 pending discarded", chan_en, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule